// File: doc/BRIEF.md
# Multi-Pipeline Binary Trie Next-Hop Lookup Engine

The block resolves the longest stored prefix for an IPv4 destination address and returns the next-hop table index linked to it. The prefix table is kept as a binary trie that is spread over several independent pipelines. The top address bits choose one pipeline. The remaining bits are then consumed one per visited trie node, most significant first, as the lookup moves down that pipeline.

Each pipeline has a fixed number of stages, and each stage owns a small node memory. A node holds three flags: a "stores a prefix" flag, a left-child flag and a right-child flag. It also holds a next-hop index and one shared children pointer, made of a stage number and an address. Because a node's children may sit in any later stage, a lookup can skip stages that hold nothing for it. The outputs of all pipelines are merged into a single result stream.

Software fills the node memories one node per cycle through a write port. The block accepts one lookup per cycle. It returns results in issue order after a fixed number of cycles.

Top module: `trie_lookup_engine`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is low and every node memory is cleared, so every lookup returns `res_hit`=0 until nodes are written.
- R2: A lookup walks only the pipeline whose index equals `req_addr[31:30]`, starting at that pipeline's root node (stage 0, address 0). Nodes written into other pipelines do not affect it.
- R3: A lookup captured at clock edge e produces exactly one result with `res_valid`=1 after edge e+5 (stages+1 cycles in the default configuration). Results come out in issue order, and idle cycles produce `res_valid`=0.
- R4: When a visited node has its prefix flag set, its next-hop index becomes the current best match. The deepest flagged node on the path is reported as `res_hit`=1 with `res_nh` equal to its index.
- R5: The next bit is taken from `req_addr[29:0]`, most significant first. A 0 bit follows the left child, found at the pointer address. A 1 bit follows the right child, found at pointer+1 when the left flag is also set and at the pointer otherwise. In both cases the child is in the pointer's stage.
- R6: A stage whose number differs from the lookup's target stage passes the lookup on unchanged, so a child may sit any number of stages after its parent.
- R7: A lookup stops walking when the flag of the child it needs is clear. It then keeps its best match to the pipeline end. With no flagged node on the path it reports `res_hit`=0 and `res_nh`=0.
- R8: A node write (`wr_en`=1) takes effect at the next clock edge and is seen by every lookup captured after that edge.
- R9: At most one pipeline delivers a result in any cycle, and the merged output carries that pipeline's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | 32 | Destination address to resolve |
| wr_en | input | 1 | Write one node this cycle |
| wr_pipe | input | 2 | Pipeline of the node written |
| wr_stage | input | 2 | Stage of the node written |
| wr_addr | input | 4 | Address of the node inside its stage |
| wr_nh_flag | input | 1 | Node stores a prefix |
| wr_has_left | input | 1 | Node has a left child |
| wr_has_right | input | 1 | Node has a right child |
| wr_nh_idx | input | 8 | Next-hop index of the stored prefix |
| wr_ptr_stage | input | 2 | Stage holding the node's children |
| wr_ptr_addr | input | 4 | Address of the first child |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | A prefix matched |
| res_nh | output | 8 | Next-hop index of the longest match |

## Verification
The in-RTL assertions watch properties that hold on every cycle:
- the selector routes each captured lookup to exactly one pipeline, the one named by its top bits, and routes nothing when idle;
- a stage that is not targeted copies the lookup unchanged;
- a found match and a finished walk are never lost further down;
- valid tokens advance one stage per cycle;
- no more than one pipeline reaches the merge at a time.

Only the bench scenarios can show the functions that depend on memory contents. These are the actual next-hop values for every path shape (left, right-at-pointer, right-at-pointer+1, stage skipping, early stop and fallback to a shallower match), the isolation of an empty pipeline, the exact five-cycle latency under back-to-back and gapped traffic, and the effect of rewriting nodes.

// File: rtl/trie_pkg.sv
// Package: trie_pkg
// Shared configuration and record types for the multi-pipeline trie lookup
// engine. Assumes SEL_W >= 1 and N_STG >= 2.
package trie_pkg;
    localparam int ADDR_W   = 32;                 // lookup key width
    localparam int SEL_W    = 2;                  // key bits choosing a pipeline
    localparam int N_PIPE   = 1 << SEL_W;         // number of pipelines
    localparam int N_STG    = 4;                  // stages per pipeline
    localparam int NODE_DEP = 16;                 // nodes per stage memory
    localparam int NH_W     = 8;                  // next-hop index width

    localparam int REM_W  = ADDR_W - SEL_W;       // key bits walked in a pipeline
    localparam int STG_W  = $clog2(N_STG);        // stage number width
    localparam int NA_W   = $clog2(NODE_DEP);     // node address width
    localparam int LAT    = N_STG + 1;            // capture-to-result cycles

    // One trie node as held in a stage memory.
    typedef struct packed {
        logic             nh_flag;   // node stores a prefix
        logic             has_l;     // left child present
        logic             has_r;     // right child present
        logic [NH_W-1:0]  nh_idx;    // next-hop index of the stored prefix
        logic [STG_W-1:0] ptr_stg;   // stage of the children
        logic [NA_W-1:0]  ptr_addr;  // address of the first child
    } node_t;

    // One lookup in flight between stages.
    typedef struct packed {
        logic             vld;       // token carries a lookup
        logic             walk;      // lookup still descending
        logic [STG_W-1:0] tstg;      // stage of the next node to visit
        logic [NA_W-1:0]  taddr;     // address of the next node to visit
        logic [REM_W-1:0] rem;       // unconsumed key bits, MSB next
        logic             hit;       // a prefix has matched so far
        logic [NH_W-1:0]  nh;        // next-hop index of best match so far
    } tok_t;
endpackage

// File: rtl/trie_selector.sv
// Module: trie_selector
// Registers an incoming lookup and hands it to the pipeline named by the top
// SEL_W key bits, primed to visit the root (stage 0, address 0). Tokens of
// pipelines not chosen are all-zero. Assumes at most one lookup per cycle.
module trie_selector
    import trie_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output tok_t [N_PIPE-1:0]      tok_o
);
    logic [SEL_W-1:0]  sel;
    logic [N_PIPE-1:0] vld_vec;

    assign sel = req_addr[ADDR_W-1 -: SEL_W];

    for (genvar p = 0; p < N_PIPE; p++) begin : g_route
        // Load the root-seeking token into the chosen pipeline only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tok_o[p] <= '0;
            end else if (req_valid && sel == SEL_W'(p)) begin
                tok_o[p].vld   <= 1'b1;
                tok_o[p].walk  <= 1'b1;
                tok_o[p].tstg  <= '0;
                tok_o[p].taddr <= '0;
                tok_o[p].rem   <= req_addr[REM_W-1:0];
                tok_o[p].hit   <= 1'b0;
                tok_o[p].nh    <= '0;
            end else begin
                tok_o[p] <= '0;
            end
        end
        assign vld_vec[p] = tok_o[p].vld;
    end

    AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $countones(vld_vec) == 1);                       // R2
    AST_ROUTE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> vld_vec[$past(sel)]);                            // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> vld_vec == '0);                                 // R3
endmodule

// File: rtl/trie_stage.sv
// Module: trie_stage
// One pipeline stage: a node memory plus one trie step. A walking lookup
// whose target stage is STG_ID reads its node, records a stored prefix as
// the new best match, consumes one key bit and aims at the matching child or
// stops. Any other token is copied unchanged. Memory reads are combinational
// from a register array; writes land at the clock edge.
module trie_stage
    import trie_pkg::*;
#(
    parameter int STG_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NA_W-1:0]   wr_addr,
    input  node_t             wr_node,
    input  tok_t              tin,
    output tok_t              tout
);
    localparam logic [STG_W-1:0] MY_STG = STG_W'(STG_ID);

    node_t mem [NODE_DEP];
    node_t nd;
    tok_t  nxt;
    logic  mine;
    logic  kbit;
    logic  take;

    // Node memory: cleared by reset, one node written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NODE_DEP; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_node;
        end
    end

    // Trie step: update best match and pick the next node or stop.
    always_comb begin
        nd   = mem[tin.taddr];
        mine = tin.vld && tin.walk && (tin.tstg == MY_STG);
        kbit = tin.rem[REM_W-1];
        take = kbit ? nd.has_r : nd.has_l;
        nxt  = tin;
        if (mine) begin
            if (nd.nh_flag) begin
                nxt.hit = 1'b1;
                nxt.nh  = nd.nh_idx;
            end
            nxt.rem = tin.rem << 1;
            if (take) begin
                nxt.tstg  = nd.ptr_stg;
                nxt.taddr = nd.ptr_addr + NA_W'(kbit & nd.has_l);
            end else begin
                nxt.walk = 1'b0;
            end
        end
    end

    // Stage register toward the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) tout <= '0;
        else        tout <= nxt;
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tin.vld && !(tin.walk && tin.tstg == MY_STG)) |=> tout == $past(tin)); // R6
    AST_BEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tin.vld && tin.hit) |=> tout.hit);                            // R4
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tin.vld && !tin.walk) |=> !tout.walk);                        // R7
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tout.vld == $past(tin.vld));                          // R3
endmodule

// File: rtl/trie_pipe.sv
// Module: trie_pipe
// A chain of N_STG trie stages for one pipeline. Decodes node writes aimed
// at this pipeline onto the addressed stage. The token leaving the last
// stage is the pipeline's result.
module trie_pipe
    import trie_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STG_W-1:0]  wr_stage,
    input  logic [NA_W-1:0]   wr_addr,
    input  node_t             wr_node,
    input  tok_t              head,
    output tok_t              tail
);
    tok_t chain [N_STG+1];

    assign chain[0] = head;

    for (genvar s = 0; s < N_STG; s++) begin : g_stg
        logic stg_wr;
        // Write strobe for this stage only.
        assign stg_wr = wr_en && (wr_stage == STG_W'(s));
        trie_stage #(.STG_ID(s)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (stg_wr),
            .wr_addr (wr_addr),
            .wr_node (wr_node),
            .tin     (chain[s]),
            .tout    (chain[s+1])
        );
    end

    assign tail = chain[N_STG];
endmodule

// File: rtl/trie_merge.sv
// Module: trie_merge
// Final selector: folds the pipeline tails into one registered result.
// Assumes at most one tail is valid per cycle, which the single-issue
// selector guarantees; invalid tails are all-zero.
module trie_merge
    import trie_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  tok_t [N_PIPE-1:0]  tails,
    output logic               res_valid,
    output logic               res_hit,
    output logic [NH_W-1:0]    res_nh
);
    logic [N_PIPE-1:0] tv;
    logic              any_v;
    logic              any_h;
    logic [NH_W-1:0]   any_nh;

    // OR-fold of valid tails; masking keeps idle pipelines out.
    always_comb begin
        any_v  = 1'b0;
        any_h  = 1'b0;
        any_nh = '0;
        for (int p = 0; p < N_PIPE; p++) begin
            tv[p]  = tails[p].vld;
            any_v  = any_v | tails[p].vld;
            any_h  = any_h | (tails[p].vld & tails[p].hit);
            any_nh = any_nh | (tails[p].vld ? tails[p].nh : '0);
        end
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_nh    <= '0;
        end else begin
            res_valid <= any_v;
            res_hit   <= any_h;
            res_nh    <= any_h ? any_nh : '0;
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tv));                                                 // R9
    for (genvar p = 0; p < N_PIPE; p++) begin : g_chk
        AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            !tails[p].vld |-> tails[p] == '0);                         // R3
        AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (tails[p].vld && !tails[p].hit) |=> (res_valid && !res_hit && res_nh == '0)); // R7
    end
endmodule

// File: rtl/trie_lookup_engine.sv
// Module: trie_lookup_engine
// Top of the multi-pipeline trie lookup engine: selector, N_PIPE pipelines
// of N_STG stages, final merge. One lookup per cycle, results after LAT
// cycles in issue order. Assumes node writes are not issued while lookups
// that depend on the written node are in flight.
module trie_lookup_engine
    import trie_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_pipe,
    input  logic [STG_W-1:0]   wr_stage,
    input  logic [NA_W-1:0]    wr_addr,
    input  logic               wr_nh_flag,
    input  logic               wr_has_left,
    input  logic               wr_has_right,
    input  logic [NH_W-1:0]    wr_nh_idx,
    input  logic [STG_W-1:0]   wr_ptr_stage,
    input  logic [NA_W-1:0]    wr_ptr_addr,
    output logic               res_valid,
    output logic               res_hit,
    output logic [NH_W-1:0]    res_nh
);
    tok_t [N_PIPE-1:0] heads;
    tok_t [N_PIPE-1:0] tails;
    node_t             wnode;

    // Pack the write fields into one node record.
    always_comb begin
        wnode.nh_flag  = wr_nh_flag;
        wnode.has_l    = wr_has_left;
        wnode.has_r    = wr_has_right;
        wnode.nh_idx   = wr_nh_idx;
        wnode.ptr_stg  = wr_ptr_stage;
        wnode.ptr_addr = wr_ptr_addr;
    end

    trie_selector u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .tok_o     (heads)
    );

    for (genvar p = 0; p < N_PIPE; p++) begin : g_pipe
        logic pipe_wr;
        // Write strobe for this pipeline only.
        assign pipe_wr = wr_en && (wr_pipe == SEL_W'(p));
        trie_pipe u_pipe (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (pipe_wr),
            .wr_stage (wr_stage),
            .wr_addr  (wr_addr),
            .wr_node  (wnode),
            .head     (heads[p]),
            .tail     (tails[p])
        );
    end

    trie_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tails     (tails),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_nh    (res_nh)
    );

    AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);                                        // R4
endmodule

// File: tb/tb_trie_lookup_engine.sv
// Bench: near-exhaustive sweep of the first three walked key bits over all
// pipelines, against an arithmetic decision table of the trie written.
module tb_trie_lookup_engine;
    import trie_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic wr_en = 1'b0;
    logic [SEL_W-1:0] wr_pipe = '0;
    logic [STG_W-1:0] wr_stage = '0;
    logic [NA_W-1:0] wr_addr = '0;
    logic wr_nh_flag = 1'b0, wr_has_left = 1'b0, wr_has_right = 1'b0;
    logic [NH_W-1:0] wr_nh_idx = '0;
    logic [STG_W-1:0] wr_ptr_stage = '0;
    logic [NA_W-1:0] wr_ptr_addr = '0;
    logic res_valid, res_hit;
    logic [NH_W-1:0] res_nh;

    trie_lookup_engine dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int tests = 0, fails = 0;
    int cyc = 0;
    int issued = 0, delivered = 0;
    bit loaded = 0, updated = 0, done = 0;
    bit log_v [64];
    logic [ADDR_W-1:0] log_a [64];

    initial for (int i = 0; i < 64; i++) begin log_v[i] = 0; log_a[i] = '0; end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected result from the trie layout written below.
    task automatic expect_of(input logic [ADDR_W-1:0] a, output bit h, output int nh);
        int p;
        int base;
        logic [2:0] b;
        p = int'(a[31:30]);
        b = a[29:27];
        base = p * 32;
        h = 0; nh = 0;
        if (!loaded || p == 3) return;
        if (b[2] == 1'b0) begin
            if (b[1] == 1'b0 && !(updated && p == 0)) begin
                h = 1; nh = (updated && p == 2) ? 8'hA5 : base + 4;
            end else if (p != 1) begin
                h = 1; nh = base;
            end
        end else begin
            h = 1;
            if (b[1] == 1'b0)      nh = base + 3;
            else if (b[0] == 1'b0) nh = base + 9;
            else                   nh = base + 7;
        end
    endtask

    // Log what is captured at each edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        log_v[(cyc + 1) % 64] <= req_valid && rst_n;
        log_a[(cyc + 1) % 64] <= req_addr;
        if (req_valid && rst_n) issued <= issued + 1;
    end

    // Output checker, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cyc > LAT && !done) begin
            bit ev, eh;
            int en;
            ev = log_v[(cyc - LAT) % 64];
            if (res_valid) delivered++;
            chk(res_valid == ev, "R3 valid timing", int'(res_valid), int'(ev));
            if (ev) begin
                expect_of(log_a[(cyc - LAT) % 64], eh, en);
                chk(res_hit == eh, "R4 R5 R7 hit", int'(res_hit), int'(eh));
                chk(int'(res_nh) == en, "R4 R5 R6 R9 next-hop", int'(res_nh), en);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0; wr_en = 1'b0;
        end
    endtask

    task automatic lookup(input int p, input int b, input int low);
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b1;
        req_addr = {2'(p), 3'(b), 27'(low)};
    endtask

    task automatic wnode(input int p, input int s, input int a, input bit f,
                         input bit l, input bit r, input int nh, input int ps, input int pa);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_pipe = 2'(p); wr_stage = 2'(s); wr_addr = 4'(a);
        wr_nh_flag = f; wr_has_left = l; wr_has_right = r; wr_nh_idx = 8'(nh);
        wr_ptr_stage = 2'(ps); wr_ptr_addr = 4'(pa);
    endtask

    task automatic sweep(input int seed, input bit gaps);
        for (int b = 0; b < 8; b++)
            for (int p = 0; p < 4; p++) begin
                lookup(p, b, seed * 32'h0123_4567 + b * 977 + p);
                if (gaps && ((b + p) % 3 == 0)) idle(1);
            end
        idle(LAT + 2);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(res_valid == 1'b0, "R1 valid low in reset", int'(res_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 valid low after reset", int'(res_valid), 0);
        // R1: empty trie misses everywhere
        sweep(0, 1'b0);
        // Load pipes 0..2; pipe 3 stays empty (R2)
        for (int p = 0; p < 3; p++) begin
            wnode(p, 0, 0, p != 1, 1, 1, p*32,     1, 2);  // root, R5 both children
            wnode(p, 1, 2, 0,      1, 1, 0,        3, 4);  // left, children skip stage 2 (R6)
            wnode(p, 1, 3, 1,      0, 1, p*32 + 3, 2, 7);  // right, right only
            wnode(p, 3, 4, 1,      0, 0, p*32 + 4, 0, 0);
            wnode(p, 3, 5, 0,      0, 0, 0,        0, 0);
            wnode(p, 2, 7, 1,      1, 0, p*32 + 7, 3, 9);  // left only
            wnode(p, 3, 9, 1,      0, 0, p*32 + 9, 0, 0);
        end
        idle(1);
        loaded = 1;
        // R2 R4 R5 R6 R7 R9: back-to-back sweeps with varying low bits
        for (int k = 1; k < 4; k++) sweep(k, 1'b0);
        // R3: gapped traffic
        sweep(7, 1'b1);
        // R8: rewrite nodes, then look again
        wnode(0, 3, 4, 0, 0, 0, 0,     0, 0);
        wnode(2, 3, 4, 1, 0, 0, 8'hA5, 0, 0);
        idle(1);
        updated = 1;
        sweep(9, 1'b0);
        sweep(11, 1'b1);
        done = 1;
        chk(delivered == issued, "R3 one result per lookup", delivered, issued);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule